// File: doc/BRIEF.md
# Carry-Save Feedback Multiply-Accumulator

This block multiplies two signed 8-bit operands and adds the product into a running total in the same clock cycle. There is no separate accumulator adder after the multiplier. Radix-4 recoding of the multiplier operand produces four rows. Those rows, their negation bits and the stored total all enter one linear chain of carry-save adder rows. Between cycles the total is kept in redundant form: an upper sum vector, an upper carry vector, and a resolved low nibble with its outgoing carry. The low nibble comes from 2-bit lookahead adders that take a carry input, so the final carry-propagate adder covers only the upper bits.

A caller pulses `in_valid` with each operand pair. It raises `clr` to discard the total, either alone or together with the first pair of a new sum. The resolved total appears on `acc_out` one cycle after the accepting edge. Its width is 20 bits, which is twice the operand width plus four guard bits, and it wraps modulo 2^20.

A two-state controller tracks whether the stored total is known to be zero. It has two states:
- `ST_IDLE`: the feedback is empty.
- `ST_ACCUM`: the feedback holds a running total.

It has two transitions:
- `IDLE->ACCUM`: taken on any accepted pair.
- `ACCUM->IDLE`: taken on `clr` without `in_valid`.

In every other case the state is held. The state gates the feedback operands into the compressor.

Top module: `cs_mac`

## Requirements
- R1: While `rst_n` is low and after it is released, `acc_out` reads 0 until a pair is accepted.
- R2: On a rising edge with `in_valid`=1 and `clr`=0, the total becomes the previous total plus A*B. Both operands are two's-complement 8-bit values and the product is sign-extended.
- R3: On an edge with `in_valid`=0 and `clr`=0, the total is unchanged, whatever values `a_in` and `b_in` carry.
- R4: On an edge with `clr`=1 and `in_valid`=0, the total becomes 0.
- R5: On an edge with `clr`=1 and `in_valid`=1, the total becomes A*B alone. The previous total is discarded.
- R6: `acc_out` is a 20-bit two's-complement value, and the total wraps modulo 2^20.
- R7: The new total is visible on `acc_out` in the cycle right after the accepting edge, through one register stage.
- R8: Extreme operands give exact products: -128*-128 = 16384, -128*127 = -16256 and 127*127 = 16129.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Discard the stored total |
| in_valid | input | 1 | Accept `a_in`/`b_in` this edge |
| a_in | input | 8 | Multiplicand, two's complement |
| b_in | input | 8 | Multiplier (recoded), two's complement |
| acc_out | output | 20 | Resolved running total, two's complement |

## Verification
Clearing and accepting a pair can fall on the same edge. In that case the block must mask the redundant feedback and load only the new product (R5), and neither clear the total to zero nor add the product to the old total. The bench provokes this case by opening the exhaustive operand sweep with `clr` and `in_valid` together. It also interleaves combined clears into a later stretch of accumulation. Each time, it compares `acc_out` against a model that restarts from the bare product. A lone clear and a lone accept on neighbouring edges are checked the same way, so that all three outcomes are told apart.

// File: rtl/cs_mac_pkg.sv
package cs_mac_pkg;
    parameter int OP_W  = 8;
    parameter int ACC_W = 2 * OP_W + 4;
    parameter int LOW_W = 4;
    localparam int ROWS  = OP_W / 2;
    localparam int N_OPS = ROWS + 4;
    localparam int HI_W  = ACC_W - LOW_W;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ACCUM = 1'b1
    } mac_state_t;
endpackage

// File: rtl/booth_rows.sv
module booth_rows #(
    parameter int OP_W  = 8,
    parameter int ACC_W = 20
) (
    input  logic [OP_W-1:0]                    a_in,
    input  logic [OP_W-1:0]                    b_in,
    output logic [OP_W/2-1:0][ACC_W-1:0]       row,
    output logic [OP_W/2-1:0]                  neg
);
    localparam int ROWS = OP_W / 2;

    logic [OP_W:0]       b_ext;
    logic [ACC_W-1:0]    a_sx;
    logic [ACC_W-1:0]    a_sx2;

    assign b_ext = {b_in, 1'b0};
    assign a_sx  = {{(ACC_W-OP_W){a_in[OP_W-1]}}, a_in};
    assign a_sx2 = a_sx << 1;

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        logic [2:0]       trip;
        logic             sel_one;
        logic             sel_two;
        logic             is_neg;
        logic [ACC_W-1:0] mag;

        assign trip    = b_ext[2*k+2 : 2*k];
        assign sel_one = trip[0] ^ trip[1];
        assign sel_two = (trip == 3'b011) || (trip == 3'b100);
        assign is_neg  = trip[2] && (trip != 3'b111);
        assign mag     = sel_one ? a_sx : (sel_two ? a_sx2 : '0);
        assign row[k]  = (is_neg ? ~mag : mag) << (2 * k);
        assign neg[k]  = is_neg;
    end
endmodule

// File: rtl/csa_chain.sv
module csa_chain #(
    parameter int N_OPS = 8,
    parameter int W     = 20
) (
    input  logic [N_OPS-1:0][W-1:0] ops,
    output logic [W-1:0]            sum_o,
    output logic [W-1:0]            carry_o
);
    logic [W-1:0] s_st [N_OPS-1];
    logic [W-1:0] c_st [N_OPS-1];

    assign s_st[0] = ops[0];
    assign c_st[0] = ops[1];

    for (genvar i = 0; i < N_OPS - 2; i++) begin : g_lvl
        logic [W-1:0] x, y, z, maj;
        assign x           = s_st[i];
        assign y           = c_st[i];
        assign z           = ops[i+2];
        assign maj         = (x & y) | (x & z) | (y & z);
        assign s_st[i+1]   = x ^ y ^ z;
        assign c_st[i+1]   = {maj[W-2:0], 1'b0};
    end

    assign sum_o   = s_st[N_OPS-2];
    assign carry_o = c_st[N_OPS-2];
endmodule

// File: rtl/cla2.sv
module cla2 (
    input  logic [1:0] a,
    input  logic [1:0] b,
    input  logic       cin,
    output logic [1:0] sum,
    output logic       cout
);
    logic [1:0] g, p;
    logic       c1;

    assign g    = a & b;
    assign p    = a ^ b;
    assign c1   = g[0] | (p[0] & cin);
    assign cout = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cin);
    assign sum  = {p[1] ^ c1, p[0] ^ cin};
endmodule

// File: rtl/cs_mac.sv
module cs_mac
    import cs_mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  a_in,
    input  logic [OP_W-1:0]  b_in,
    output logic [ACC_W-1:0] acc_out
);
    localparam int N_CLA = LOW_W / 2;

    mac_state_t state_q, state_d;

    logic [HI_W-1:0]  sum_hi_q, carry_hi_q;
    logic [LOW_W-1:0] low_res_q;
    logic             low_cy_q;

    logic [ROWS-1:0][ACC_W-1:0]  rows;
    logic [ROWS-1:0]             neg;
    logic [ACC_W-1:0]            neg_vec;
    logic [N_OPS-1:0][ACC_W-1:0] ops;
    logic [ACC_W-1:0]            cs_sum, cs_carry;
    logic                        fb_en;
    logic [LOW_W-1:0]            low_res_d;
    logic [N_CLA:0]              cla_c;

    booth_rows #(.OP_W(OP_W), .ACC_W(ACC_W)) u_rows (
        .a_in (a_in),
        .b_in (b_in),
        .row  (rows),
        .neg  (neg)
    );

    always_comb begin
        neg_vec = '0;
        for (int k = 0; k < ROWS; k++) neg_vec[2*k] = neg[k];
    end

    assign fb_en = (state_q == ST_ACCUM) && !clr;

    always_comb begin
        for (int k = 0; k < ROWS; k++) ops[k] = rows[k];
        ops[ROWS]   = neg_vec;
        ops[ROWS+1] = fb_en ? {sum_hi_q, low_res_q} : '0;
        ops[ROWS+2] = fb_en ? {carry_hi_q, {LOW_W{1'b0}}} : '0;
        ops[ROWS+3] = fb_en ? (ACC_W'(low_cy_q) << LOW_W) : '0;
    end

    csa_chain #(.N_OPS(N_OPS), .W(ACC_W)) u_csa (
        .ops     (ops),
        .sum_o   (cs_sum),
        .carry_o (cs_carry)
    );

    assign cla_c[0] = 1'b0;
    for (genvar j = 0; j < N_CLA; j++) begin : g_cla
        cla2 u_cla (
            .a    (cs_sum[2*j+1 : 2*j]),
            .b    (cs_carry[2*j+1 : 2*j]),
            .cin  (cla_c[j]),
            .sum  (low_res_d[2*j+1 : 2*j]),
            .cout (cla_c[j+1])
        );
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (in_valid)         state_d = ST_ACCUM;
            ST_ACCUM: if (clr && !in_valid) state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || (clr && !in_valid)) begin
            sum_hi_q   <= '0;
            carry_hi_q <= '0;
            low_res_q  <= '0;
            low_cy_q   <= 1'b0;
        end else if (in_valid) begin
            sum_hi_q   <= cs_sum[ACC_W-1:LOW_W];
            carry_hi_q <= cs_carry[ACC_W-1:LOW_W];
            low_res_q  <= low_res_d;
            low_cy_q   <= cla_c[N_CLA];
        end
    end

    always_comb begin
        acc_out = {sum_hi_q + carry_hi_q + HI_W'(low_cy_q), low_res_q};
    end

    logic signed [ACC_W-1:0] chk_a, chk_b;
    logic        [ACC_W-1:0] chk_prod;
    assign chk_a    = $signed(a_in);
    assign chk_b    = $signed(b_in);
    assign chk_prod = chk_a * chk_b;

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> acc_out == '0);                                   // R1
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !clr) |=> acc_out == $past(acc_out) + $past(chk_prod)); // R2
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !clr) |=> $stable(acc_out));                   // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !in_valid) |=> acc_out == '0);                       // R4
    AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && in_valid) |=> acc_out == $past(chk_prod));           // R5
    AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> acc_out == '0);                     // R1
endmodule

// File: tb/sim_cs_mac.sv
module sim_cs_mac;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clr = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  a_in = '0;
    logic [7:0]  b_in = '0;
    logic [19:0] acc_out;

    int n_vec  = 0;
    int n_fail = 0;
    logic [19:0] model = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cs_mac u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .in_valid (in_valid),
        .a_in     (a_in),
        .b_in     (b_in),
        .acc_out  (acc_out)
    );

    function automatic logic [19:0] prod(input logic [7:0] a, input logic [7:0] b);
        int ai, bi;
        ai = int'($signed(a));
        bi = int'($signed(b));
        return 20'(ai * bi);
    endfunction

    task automatic check(input string req, input logic [19:0] exp);
        n_vec++;
        if (acc_out !== exp) begin
            n_fail++;
            $display("FAIL %s: acc_out=%h expected=%h", req, acc_out, exp);
        end
    endtask

    // drive at negedge, let one edge pass, compare at the following negedge
    task automatic step(input logic [7:0] a, input logic [7:0] b,
                        input logic v, input logic c, input string req);
        a_in = a; b_in = b; in_valid = v; clr = c;
        @(posedge clk);
        if (c)      model = v ? prod(a, b) : '0;
        else if (v) model = model + prod(a, b);
        @(negedge clk);
        check(req, model);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: acc_out=%h expected=finish", acc_out);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", 20'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 20'h0);

        // R5: combined clear and accept opens the sweep
        step(8'd3, 8'd5, 1'b1, 1'b1, "R5 clear+load");
        // R2/R6/R7: exhaustive operand sweep, total wraps many times
        for (int ia = 0; ia < 256; ia++)
            for (int ib = 0; ib < 256; ib++)
                step(8'(ia), 8'(ib), 1'b1, 1'b0, "R2 R6 R7 sweep");

        // R3: garbage operands without in_valid
        for (int i = 0; i < 4; i++)
            step(8'(37 * i + 11), 8'(91 * i + 5), 1'b0, 1'b0, "R3 hold");

        // R4: lone clear, then hold at zero
        step(8'h7f, 8'h7f, 1'b0, 1'b1, "R4 clear");
        step(8'h80, 8'h80, 1'b0, 1'b0, "R3 hold after clear");

        // R8: extreme operands
        step(8'h80, 8'h80, 1'b1, 1'b1, "R8 -128*-128");
        check("R8 value 16384", 20'd16384);
        step(8'h80, 8'h7f, 1'b1, 1'b1, "R8 -128*127");
        check("R8 value -16256", 20'(-16256));
        step(8'h7f, 8'h7f, 1'b1, 1'b1, "R8 127*127");
        check("R8 value 16129", 20'd16129);

        // R6: 64 * 16384 = 2^20 wraps back to zero
        step(8'h80, 8'h80, 1'b1, 1'b1, "R6 wrap start");
        for (int i = 1; i < 64; i++)
            step(8'h80, 8'h80, 1'b1, 1'b0, "R6 wrap");
        check("R6 wrapped to zero", 20'h0);

        // R5 interleaved with accumulation and lone clears
        for (int i = 0; i < 300; i++) begin
            logic [7:0] a, b;
            a = 8'(i * 53 + 7);
            b = 8'(i * 29 + 200);
            if (i % 11 == 0)     step(a, b, 1'b1, 1'b1, "R5 interleaved");
            else if (i % 17 == 0) step(a, b, 1'b0, 1'b1, "R4 interleaved");
            else if (i % 5 == 0)  step(a, b, 1'b0, 1'b0, "R3 interleaved");
            else                  step(a, b, 1'b1, 1'b0, "R2 interleaved");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule